// File: doc/BRIEF.md
# Weighted-Sum Correlation Sampler

This block couples a small network of stochastic binary units into a Boltzmann-style network. At the start of each sampling interval it captures the present output of every unit. For each unit it then forms a signed local field: that unit's bias plus the sum of symmetric pair weights taken over every other unit. Each weight is added when the other unit reads 1 and subtracted when it reads 0, so unit outputs count as ±1. The field is scaled by a global coupling strength, which acts as an inverse temperature, and offset to the mid-scale of a 10-bit input code. The result is then saturated to the code range. A single multiply-accumulate datapath visits the units one after another.

Once every unit's code is ready, all codes are published together with a one-cycle update strobe. They then stay fixed for a programmable number of hold cycles before the next capture. The captured state is presented alongside the codes so that an external logger can build long-run histograms. A three-unit monitor value packs units 0, 1 and 2 as 4·A + 2·B + C. A clamp mask can force any unit's code to zero or full scale. This pins that unit to 0 or 1 and lets a gate built from the network run forward or inverted. The whole interval must stay well below the shortest retention time of the units it drives.

Top module: `wsum_sampler`

## Requirements
- R1: While reset is low and until the first update strobe after it, every code reads 512, update_o is 0, log_state_o is 0 and monitor_o is 0.
- R2: For an unclamped unit k, the published code equals 512 + floor(S·F/64), saturated. F = bias[k] + Σ over j≠k of (state[j] ? +W[k][j] : −W[k][j]). Bias entry k is signed 8-bit at bias_i bits [8k+7:8k]. W[k][j] is signed 8-bit at weight_i bits [8(8k+j)+7 : 8(8k+j)]. S is the unsigned 8-bit strength_i, so strength 64 means a gain of 1.0. Code k sits at code_o bits [10k+9:10k].
- R3: The diagonal weight W[k][k] has no effect on code k.
- R4: A result below 0 is published as 0, and a result above 1023 is published as 1023.
- R5: With strength_i equal to 0, every unclamped code is 512, whatever the states, weights and biases.
- R6: When clamp_en_i[k] is 1 at publication, code k is 1023 if clamp_val_i[k] is 1 and 0 if it is 0. The computed value is overridden.
- R7: update_o is a single-cycle pulse. Consecutive pulses are N·(N+1)+3+hold_i cycles apart, which is 75+hold_i for N=8.
- R8: code_o changes only in a cycle in which update_o is high.
- R9: The codes and log_state_o published at a strobe come from unit states captured once, at the start of that interval. A change of unit_state_i after the capture has no effect until the following interval.
- R10: monitor_o equals 4·log_state_o[0] + 2·log_state_o[1] + log_state_o[2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_state_i | input | N | Present outputs of the stochastic units (1 = +1, 0 = −1) |
| bias_i | input | N*8 | Signed per-unit bias table |
| weight_i | input | N*N*8 | Signed pair-weight table, row k column j at entry N·k+j |
| strength_i | input | 8 | Coupling strength, unsigned with 6 fraction bits |
| hold_i | input | 16 | Extra hold cycles per sampling interval |
| clamp_en_i | input | N | Per-unit clamp enable |
| clamp_val_i | input | N | Per-unit clamp level (1 = full scale, 0 = zero) |
| code_o | output | N*10 | Published per-unit input codes |
| update_o | output | 1 | One-cycle strobe when new codes and state are published |
| log_state_o | output | N | Unit states captured for the published interval |
| monitor_o | output | 3 | Packed monitor value of units 0, 1, 2 |

## Verification
The hardest case to reach from the ports is a unit changing state in the middle of an accumulation. The published codes must still reflect the state captured at the interval's start. The stimulus waits for a strobe and then counts past the hold window and the capture cycle. It flips the unit states while the datapath is partway through the rows, and expects the old state in the next strobe and the new state in the one after. The diagonal weights are also driven to extreme values to show they cannot leak into a field. Strength settings large enough to saturate both ends of the code range complete the corner cases.

// File: rtl/ws_pkg.sv
package ws_pkg;

  typedef enum logic [2:0] {
    PH_SNAP = 3'd0,
    PH_MAC  = 3'd1,
    PH_FIN  = 3'd2,
    PH_PUB  = 3'd3,
    PH_HOLD = 3'd4
  } ws_phase_e;

  // Contribution of one neighbour to a local field: +w when on, -w when off.
  function automatic int spin_term(logic is_self, logic bit_on, int w);
    if (is_self) return 0;
    return bit_on ? w : -w;
  endfunction

  // Scale a field by strength (frac fraction bits), offset to mid-scale, saturate.
  function automatic int field_to_code(int field, int strength, int frac, int code_w);
    int prod;
    int val;
    int top;
    prod = field * strength;
    val  = (prod >>> frac) + (1 << (code_w - 1));
    top  = (1 << code_w) - 1;
    if (val < 0) return 0;
    if (val > top) return top;
    return val;
  endfunction

endpackage

// File: rtl/ws_sequencer.sv
module ws_sequencer #(
  parameter int N      = 8,
  parameter int HOLD_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              snap_stb,
  output logic              mac_en,
  output logic              fin_stb,
  output logic              pub_stb,
  output logic              row_start,
  output logic [IDX_W-1:0]  load_row,
  output logic [IDX_W-1:0]  row_idx,
  output logic [IDX_W-1:0]  col_idx
);
  import ws_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  ws_phase_e         ph;
  logic [IDX_W-1:0]  row_q;
  logic [IDX_W-1:0]  col_q;
  logic [HOLD_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= PH_SNAP;
      row_q <= '0;
      col_q <= '0;
      cnt_q <= '0;
    end else begin
      case (ph)
        PH_SNAP: begin
          row_q <= '0;
          col_q <= '0;
          ph    <= PH_MAC;
        end
        PH_MAC: begin
          if (col_q == LAST) ph <= PH_FIN;
          else col_q <= col_q + 1'b1;
        end
        PH_FIN: begin
          col_q <= '0;
          if (row_q == LAST) ph <= PH_PUB;
          else begin
            row_q <= row_q + 1'b1;
            ph    <= PH_MAC;
          end
        end
        PH_PUB: begin
          cnt_q <= hold_i;
          ph    <= PH_HOLD;
        end
        PH_HOLD: begin
          if (cnt_q == '0) ph <= PH_SNAP;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: ph <= PH_SNAP;
      endcase
    end
  end

  always_comb begin
    snap_stb  = (ph == PH_SNAP);
    mac_en    = (ph == PH_MAC);
    fin_stb   = (ph == PH_FIN);
    pub_stb   = (ph == PH_PUB);
    row_start = snap_stb || (fin_stb && (row_q != LAST));
    load_row  = snap_stb ? '0 : row_q + 1'b1;
    row_idx   = row_q;
    col_idx   = col_q;
  end

endmodule

// File: rtl/ws_mac.sv
module ws_mac #(
  parameter int N     = 8,
  parameter int WT_W  = 8,
  parameter int ACC_W = 12,
  parameter int IDX_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    row_start,
  input  logic [IDX_W-1:0]        load_row,
  input  logic                    mac_en,
  input  logic [IDX_W-1:0]        row_idx,
  input  logic [IDX_W-1:0]        col_idx,
  input  logic [N-1:0]            snap_state,
  input  logic [N*WT_W-1:0]       bias_flat,
  input  logic [N*N*WT_W-1:0]     weight_flat,
  output logic signed [ACC_W-1:0] acc_o
);
  import ws_pkg::*;

  logic signed [WT_W-1:0]  bias_sel;
  logic signed [WT_W-1:0]  wgt_sel;
  logic signed [ACC_W-1:0] term;
  logic signed [ACC_W-1:0] acc_q;
  int                      widx;
  int                      bidx;

  always_comb begin
    bidx     = int'(load_row) * WT_W;
    widx     = (int'(row_idx) * N + int'(col_idx)) * WT_W;
    bias_sel = bias_flat[bidx +: WT_W];
    wgt_sel  = weight_flat[widx +: WT_W];
    term     = ACC_W'(spin_term(row_idx == col_idx, snap_state[col_idx], int'(wgt_sel)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else if (row_start) acc_q <= {{(ACC_W-WT_W){bias_sel[WT_W-1]}}, bias_sel};
    else if (mac_en) acc_q <= acc_q + term;
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/ws_code_bank.sv
module ws_code_bank #(
  parameter int N      = 8,
  parameter int CODE_W = 10,
  parameter int STR_W  = 8,
  parameter int FRAC   = 6,
  parameter int ACC_W  = 12,
  parameter int IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fin_stb,
  input  logic [IDX_W-1:0]        row_idx,
  input  logic signed [ACC_W-1:0] acc_i,
  input  logic [STR_W-1:0]        strength_i,
  input  logic                    pub_stb,
  input  logic [N-1:0]            clamp_en_i,
  input  logic [N-1:0]            clamp_val_i,
  output logic [N*CODE_W-1:0]     code_flat
);
  import ws_pkg::*;

  localparam logic [CODE_W-1:0] MID = CODE_W'(1 << (CODE_W - 1));

  logic [CODE_W-1:0] shadow [N];
  logic [CODE_W-1:0] next_code;

  always_comb next_code = CODE_W'(field_to_code(int'(acc_i), int'(strength_i), FRAC, CODE_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) shadow[k] <= MID;
    end else if (fin_stb) begin
      shadow[row_idx] <= next_code;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_unit
    logic [CODE_W-1:0] pub_q;
    always_ff @(posedge clk) begin
      if (!rst_n) pub_q <= MID;
      else if (pub_stb) begin
        if (clamp_en_i[g]) pub_q <= clamp_val_i[g] ? '1 : '0;
        else pub_q <= shadow[g];
      end
    end
    assign code_flat[g*CODE_W +: CODE_W] = pub_q;
  end

endmodule

// File: rtl/wsum_sampler.sv
module wsum_sampler #(
  parameter int N      = 8,
  parameter int WT_W   = 8,
  parameter int STR_W  = 8,
  parameter int FRAC   = 6,
  parameter int CODE_W = 10,
  parameter int HOLD_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          unit_state_i,
  input  logic [N*WT_W-1:0]     bias_i,
  input  logic [N*N*WT_W-1:0]   weight_i,
  input  logic [STR_W-1:0]      strength_i,
  input  logic [HOLD_W-1:0]     hold_i,
  input  logic [N-1:0]          clamp_en_i,
  input  logic [N-1:0]          clamp_val_i,
  output logic [N*CODE_W-1:0]   code_o,
  output logic                  update_o,
  output logic [N-1:0]          log_state_o,
  output logic [2:0]            monitor_o
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam int ACC_W = WT_W + IDX_W + 1;

  // Named internal events, visible to the bound checker.
  logic                    snap_stb;
  logic                    mac_en;
  logic                    fin_stb;
  logic                    pub_stb;
  logic                    row_start;
  logic [IDX_W-1:0]        load_row;
  logic [IDX_W-1:0]        row_idx;
  logic [IDX_W-1:0]        col_idx;
  logic signed [ACC_W-1:0] acc;
  logic [N-1:0]            snap_q;
  logic [N-1:0]            log_q;
  logic [2:0]              mon_q;
  logic                    upd_q;

  ws_sequencer #(.N(N), .HOLD_W(HOLD_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i),
    .snap_stb(snap_stb), .mac_en(mac_en), .fin_stb(fin_stb), .pub_stb(pub_stb),
    .row_start(row_start), .load_row(load_row), .row_idx(row_idx), .col_idx(col_idx)
  );

  ws_mac #(.N(N), .WT_W(WT_W), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .row_start(row_start), .load_row(load_row),
    .mac_en(mac_en), .row_idx(row_idx), .col_idx(col_idx), .snap_state(snap_q),
    .bias_flat(bias_i), .weight_flat(weight_i), .acc_o(acc)
  );

  ws_code_bank #(.N(N), .CODE_W(CODE_W), .STR_W(STR_W), .FRAC(FRAC),
                 .ACC_W(ACC_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .fin_stb(fin_stb), .row_idx(row_idx), .acc_i(acc),
    .strength_i(strength_i), .pub_stb(pub_stb), .clamp_en_i(clamp_en_i),
    .clamp_val_i(clamp_val_i), .code_flat(code_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q <= '0;
      log_q  <= '0;
      mon_q  <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= pub_stb;
      if (snap_stb) snap_q <= unit_state_i;
      if (pub_stb) begin
        log_q <= snap_q;
        mon_q <= {snap_q[0], snap_q[1], snap_q[2]};
      end
    end
  end

  assign update_o    = upd_q;
  assign log_state_o = log_q;
  assign monitor_o   = mon_q;

endmodule

// File: rtl/wsum_sampler_chk.sv
module wsum_sampler_chk #(
  parameter int N      = 8,
  parameter int CODE_W = 10,
  parameter int STR_W  = 8,
  parameter int HOLD_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                update_o,
  input logic [N*CODE_W-1:0] code_o,
  input logic [HOLD_W-1:0]   hold_i,
  input logic [STR_W-1:0]    strength_i,
  input logic [N-1:0]        clamp_en_i,
  input logic [N-1:0]        clamp_val_i
);

  localparam logic [CODE_W-1:0] MID  = CODE_W'(1 << (CODE_W - 1));
  localparam int                BASE = N * (N + 1) + 3;

  int                gap_q;
  logic              seen_q;
  logic [HOLD_W-1:0] hold_q;
  logic              nz_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
      hold_q <= '0;
      nz_q   <= 1'b0;
    end else if (update_o) begin
      gap_q  <= 1;
      seen_q <= 1'b1;
      hold_q <= hold_i;
      nz_q   <= (strength_i != '0);
    end else begin
      gap_q <= gap_q + 1;
      if (strength_i != '0) nz_q <= 1'b1;
    end
  end

  // R7: strobe lasts one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |=> !update_o);

  // R7: spacing of strobes
  a_r7_period: assert property (@(posedge clk) disable iff (!rst_n)
    (update_o && seen_q) |-> (gap_q == BASE + int'(hold_q)));

  // R8: codes hold between strobes
  a_r8_codes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !update_o |=> (update_o || $stable(code_o)));

  for (genvar k = 0; k < N; k++) begin : g_chk
    // R6: clamp overrides the computed code
    a_r6_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (update_o && $past(clamp_en_i[k])) |->
        (code_o[k*CODE_W +: CODE_W] == ($past(clamp_val_i[k]) ? {CODE_W{1'b1}} : {CODE_W{1'b0}})));

    // R5: zero strength yields mid-scale
    a_r5_zero_strength: assert property (@(posedge clk) disable iff (!rst_n)
      (update_o && !nz_q && !$past(clamp_en_i[k])) |-> (code_o[k*CODE_W +: CODE_W] == MID));
  end

endmodule

bind wsum_sampler wsum_sampler_chk #(.N(N), .CODE_W(CODE_W), .STR_W(STR_W), .HOLD_W(HOLD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .update_o(update_o), .code_o(code_o), .hold_i(hold_i),
  .strength_i(strength_i), .clamp_en_i(clamp_en_i), .clamp_val_i(clamp_val_i)
);

// File: tb/sim_wsum_sampler.sv
module sim_wsum_sampler;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int WT_W = 8;
  localparam int CODE_W = 10;
  localparam int HOLD = 3;
  localparam int NV = 7;

  localparam logic [7:0] V_STATE [NV] = '{8'hFF, 8'h00, 8'hA5, 8'h3C, 8'h81, 8'h5A, 8'h0F};
  localparam logic [7:0] V_STR   [NV] = '{8'd255, 8'd255, 8'd51, 8'd64, 8'd0, 8'd200, 8'd20};
  localparam int         V_SEED  [NV] = '{0, 0, 3, 5, 7, 11, 2};

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [N-1:0]         unit_state_i = '0;
  logic [N*WT_W-1:0]    bias_i = '0;
  logic [N*N*WT_W-1:0]  weight_i = '0;
  logic [7:0]           strength_i = '0;
  logic [15:0]          hold_i = 16'(HOLD);
  logic [N-1:0]         clamp_en_i = '0;
  logic [N-1:0]         clamp_val_i = '0;
  logic [N*CODE_W-1:0]  code_o;
  logic                 update_o;
  logic [N-1:0]         log_state_o;
  logic [2:0]           monitor_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wsum_sampler u0 (
    .clk(clk), .rst_n(rst_n), .unit_state_i(unit_state_i), .bias_i(bias_i),
    .weight_i(weight_i), .strength_i(strength_i), .hold_i(hold_i),
    .clamp_en_i(clamp_en_i), .clamp_val_i(clamp_val_i), .code_o(code_o),
    .update_o(update_o), .log_state_o(log_state_o), .monitor_o(monitor_o)
  );

  function automatic int wgt(int i, int j, int seed);
    int lo, hi;
    if (seed == 0) return 100;
    lo = (i < j) ? i : j;
    hi = (i < j) ? j : i;
    return ((lo * 31 + hi * 17 + seed * 53 + lo * hi * seed) % 256) - 128;
  endfunction

  function automatic int bias_of(int i, int seed);
    if (seed == 0) return 100;
    return ((i * 29 + seed * 41) % 256) - 128;
  endfunction

  // Expected code per the requirements, computed by direct summation and floor division.
  function automatic int expect_code(int k, logic [7:0] st, int str, int seed,
                                     logic [7:0] cen, logic [7:0] cval);
    int f, p, q, v;
    if (cen[k]) return cval[k] ? 1023 : 0;
    f = bias_of(k, seed);
    for (int j = 0; j < N; j++) begin
      if (j != k) f = f + (st[j] ? wgt(k, j, seed) : -wgt(k, j, seed));
    end
    p = f * str;
    q = (p >= 0) ? (p / 64) : -((-p + 63) / 64);
    v = 512 + q;
    if (v < 0) v = 0;
    if (v > 1023) v = 1023;
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load_net(int seed);
    for (int i = 0; i < N; i++) begin
      bias_i[i*WT_W +: WT_W] = 8'(bias_of(i, seed));
      for (int j = 0; j < N; j++) weight_i[(i*N+j)*WT_W +: WT_W] = 8'(wgt(i, j, seed));
    end
  endtask

  task automatic wait_pub();
    @(negedge clk);
    while (update_o !== 1'b1) @(negedge clk);
  endtask

  // From one strobe to the next: cycle count and whether codes moved between.
  task automatic wait_interval(output int cyc, output bit moved);
    logic [N*CODE_W-1:0] ref_c;
    ref_c = code_o;
    cyc = 0;
    moved = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (update_o !== 1'b1 && code_o !== ref_c) moved = 1;
    end while (update_o !== 1'b1);
  endtask

  task automatic check_codes(string req, logic [7:0] st, int str, int seed,
                             logic [7:0] cen, logic [7:0] cval);
    int bad_k, act, exp;
    bad_k = -1; act = 0; exp = 0;
    for (int k = 0; k < N; k++) begin
      if (bad_k < 0 && int'(code_o[k*CODE_W +: CODE_W]) != expect_code(k, st, str, seed, cen, cval)) begin
        bad_k = k;
        act = int'(code_o[k*CODE_W +: CODE_W]);
        exp = expect_code(k, st, str, seed, cen, cval);
      end
    end
    check(bad_k < 0, req, $sformatf("code unit %0d", bad_k), act, exp);
  endtask

  task automatic run_vec(string req, logic [7:0] st, logic [7:0] str, int seed,
                         logic [7:0] cen, logic [7:0] cval);
    int cyc;
    bit moved;
    @(negedge clk);
    unit_state_i = st; strength_i = str; clamp_en_i = cen; clamp_val_i = cval;
    load_net(seed);
    wait_pub();
    wait_interval(cyc, moved);
    check_codes(req, st, int'(str), seed, cen, cval);
    check(log_state_o == st, "R9", "log_state", int'(log_state_o), int'(st));
    check(int'(monitor_o) == 4*st[0] + 2*st[1] + st[2], "R10", "monitor",
          int'(monitor_o), 4*st[0] + 2*st[1] + st[2]);
    check(cyc == N*(N+1) + 3 + HOLD, "R7", "strobe spacing", cyc, N*(N+1) + 3 + HOLD);
    check(!moved, "R8", "codes moved between strobes", int'(moved), 0);
  endtask

  task automatic run_all();
    bit bad;
    // R1: reset state
    repeat (3) @(negedge clk);
    bad = 0;
    for (int k = 0; k < N; k++) if (code_o[k*CODE_W +: CODE_W] !== 10'd512) bad = 1;
    check(!bad && update_o === 1'b0 && log_state_o === '0 && monitor_o === '0,
          "R1", "reset outputs", int'(bad), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    bad = 0;
    for (int k = 0; k < N; k++) if (code_o[k*CODE_W +: CODE_W] !== 10'd512) bad = 1;
    check(!bad && update_o === 1'b0, "R1", "codes before first strobe", int'(bad), 0);

    // Table walk: R2 general, R4 saturation (rows 0,1), R5 zero strength (row 4), R3 via nonzero diagonals
    for (int v = 0; v < NV; v++) begin
      run_vec((v < 2) ? "R4" : ((v == 4) ? "R5" : "R2"), V_STATE[v], V_STR[v], V_SEED[v], 8'h00, 8'h00);
    end

    // R3: extreme diagonal weights leave codes unchanged
    @(negedge clk);
    unit_state_i = 8'h3C; strength_i = 8'd64; clamp_en_i = '0; clamp_val_i = '0;
    load_net(5);
    for (int i = 0; i < N; i++) weight_i[(i*N+i)*WT_W +: WT_W] = (i % 2 == 0) ? 8'h7F : 8'h80;
    wait_pub(); wait_pub();
    check_codes("R3", 8'h3C, 64, 5, 8'h00, 8'h00);

    // R6: clamp to full scale and to zero over computed values
    run_vec("R6", 8'hA5, 8'd51, 3, 8'b1000_0011, 8'b1000_0001);
    run_vec("R6", 8'hFF, 8'd255, 0, 8'b0000_0100, 8'b0000_0000);

    // R9: state change after capture does not reach the current interval
    @(negedge clk);
    clamp_en_i = '0; clamp_val_i = '0; strength_i = 8'd51; unit_state_i = 8'hA5;
    load_net(3);
    wait_pub(); wait_pub();
    repeat (HOLD + 10) @(negedge clk);
    unit_state_i = 8'h5A;
    wait_pub();
    check(log_state_o == 8'hA5, "R9", "log after late change", int'(log_state_o), 8'hA5);
    check_codes("R9", 8'hA5, 51, 3, 8'h00, 8'h00);
    wait_pub();
    check(log_state_o == 8'h5A, "R9", "log next interval", int'(log_state_o), 8'h5A);
    check_codes("R9", 8'h5A, 51, 3, 8'h00, 8'h00);
    @(negedge clk);
    check(update_o === 1'b0, "R7", "strobe width", int'(update_o), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (60000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL R7 watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule